// File: doc/BRIEF.md
# Goldschmidt Floating-Point Square Root

This block computes the square root of a single floating-point operand whose exponent and mantissa widths are parameters. The operand is split into sign, exponent and mantissa. When the unbiased exponent is odd, the mantissa is doubled and the exponent lowered by one, so that the exponent can be halved exactly. The significand, now in [1,4), is refined by coupled Goldschmidt iterations. These start from a reciprocal-square-root seed read from a table whose entries cover [1,4) in equal slices.

Two variables are iterated. The first, g, tends to sqrt(M). The second, h, tends to 1/(2·sqrt(M)). Each iteration first forms a shared residual r = 0.5 − g·h in one cycle, then updates g += g·r and h += h·r together in the next cycle. The loop needs no divider. The same two fixed-point multipliers are reused in every phase, and a state machine counts the iterations.

Operands enter on a valid/ready input port and results leave on a valid/ready output port. The unit holds one operation at a time. `in_ready` is high only while the unit is idle. A finished result stays on `out_data` until the consumer raises `out_ready`, and no new operand is taken during that wait, so back-pressure on the output stalls the input. Special operands produce their result straight from the unpack stage. Results are truncated, and subnormal operands are treated as zero.

Top module: `fp_sqrt_gs`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An operand is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until that result has been handed over.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_invalid` hold their values. A rising edge with `out_valid` and `out_ready` both high clears `out_valid` and returns `in_ready` to 1.
- R3: For a positive normal operand, the result is within 2 units in the last place of the exact square root, and its sign bit is 0.
- R4: The result exponent field equals floor((E − bias)/2) + bias for a result that is not near a power of two. With 8/23 widths: operand 2.0 gives field 127, operand 8.0 gives field 128, and operand 0.5 gives field 126.
- R5: `out_valid` rises on the rising edge numbered L, where the accepting edge counts as 1. For a normal positive operand L = 2·ITERS + 3, which is 9 for the default ITERS = 3. For every special operand L = 1.
- R6: A negative operand that is not zero, including negative infinity, gives a quiet NaN and `out_invalid` = 1. The quiet NaN has sign 0, all exponent bits 1, the mantissa MSB 1 and the other mantissa bits 0 (0x7FC00000 for 8/23 widths).
- R7: Any NaN operand (all exponent bits 1, mantissa nonzero) gives the same quiet NaN with `out_invalid` = 1.
- R8: An operand with exponent field 0 (zero or subnormal) gives a zero result that keeps the operand's sign bit, with all other bits 0, and `out_invalid` = 0.
- R9: Positive infinity (0x7F800000 for 8/23 widths) gives positive infinity with `out_invalid` = 0.
- R10: `out_invalid` is 0 for every positive normal operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is present on `in_data` |
| in_ready | output | 1 | Unit is idle and can take an operand |
| in_data | input | 1+EXP_W+MAN_W | Operand: sign, biased exponent, mantissa |
| out_valid | output | 1 | Result is present on `out_data` |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 1+EXP_W+MAN_W | Square root result |
| out_invalid | output | 1 | Result is the quiet NaN from a negative or NaN operand |

## Verification
The result of a normal operand is due on the (2·ITERS+3)-th rising edge, counting the accepting edge as the first. A special operand's result is due on the accepting edge itself. The bench drives and samples at falling edges and counts falling edges from the acceptance edge to the first one at which `out_valid` is seen high, so the count equals the edge number L. It then compares that count with the expected value for the operand class. Values are read in the same falling-edge window. During the back-pressure scenario the held output and the low `in_ready` are checked at every falling edge of the stall.

// File: rtl/gsqrt_pkg.sv
package gsqrt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_RES,
    ST_UPD,
    ST_NORM,
    ST_OUT
  } gs_state_e;

  // Integer square root, bit by bit from the top, for constant seed generation
  function automatic longint unsigned isqrt64(input longint unsigned v);
    longint unsigned acc;
    longint unsigned trial;
    acc = 0;
    for (int i = 31; i >= 0; i--) begin
      trial = acc | (64'd1 << i);
      if (trial * trial <= v) acc = trial;
    end
    return acc;
  endfunction

endpackage

// File: rtl/gsqrt_unpack.sv
module gsqrt_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GUARD = 6,
  localparam int DW   = 1 + EXP_W + MAN_W,
  localparam int F    = MAN_W + GUARD,
  localparam int W    = F + 3
) (
  input  logic [DW-1:0]       op,
  output logic                is_special,
  output logic [DW-1:0]       special_word,
  output logic                special_flag,
  output logic signed [W-1:0] m_fix,
  output logic [EXP_W-1:0]    half_exp
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [DW-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [DW-1:0] PINF_W = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic                     sgn;
  logic [EXP_W-1:0]         efld;
  logic [MAN_W-1:0]         mfld;
  logic                     e_all1, e_all0;
  logic signed [EXP_W+1:0]  e_unb, e_even, e_res;
  logic                     odd;
  logic signed [W-1:0]      m_base;

  assign sgn    = op[DW-1];
  assign efld   = op[DW-2:MAN_W];
  assign mfld   = op[MAN_W-1:0];
  assign e_all1 = &efld;
  assign e_all0 = ~|efld;

  // Unbiased exponent made even; odd exponents move one factor of two into M
  assign e_unb  = $signed({2'b00, efld}) - $signed((EXP_W+2)'(BIAS));
  assign odd    = e_unb[0];
  assign e_even = e_unb - $signed({{(EXP_W+1){1'b0}}, odd});
  assign e_res  = (e_even >>> 1) + $signed((EXP_W+2)'(BIAS));
  assign half_exp = EXP_W'(e_res);

  assign m_base = W'({1'b1, mfld}) << GUARD;
  assign m_fix  = odd ? (m_base <<< 1) : m_base;

  always_comb begin
    is_special   = 1'b1;
    special_flag = 1'b0;
    special_word = '0;
    if (e_all1 && (mfld != '0)) begin
      special_word = QNAN_W;
      special_flag = 1'b1;
    end else if (e_all0) begin
      special_word = {sgn, {(DW-1){1'b0}}};
    end else if (sgn) begin
      special_word = QNAN_W;
      special_flag = 1'b1;
    end else if (e_all1) begin
      special_word = PINF_W;
    end else begin
      is_special = 1'b0;
    end
  end

endmodule

// File: rtl/gsqrt_seed_rom.sv
module gsqrt_seed_rom #(
  parameter int DEPTH   = 16,
  parameter int SEED_FB = 12,
  parameter int F       = 29,
  parameter int W       = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic signed [W-1:0] m_fix,
  output logic signed [W-1:0] y0
);
  import gsqrt_pkg::*;

  localparam logic signed [W-1:0] ONE_FX = {{(W-F-1){1'b0}}, 1'b1, {F{1'b0}}};

  // Seed for slice k of [1,4): 1/sqrt of the slice midpoint
  function automatic logic [SEED_FB:0] seed_at(input int k);
    longint unsigned den, num;
    den = longint'(2 * DEPTH);
    num = longint'(2 * DEPTH + 3 * (2 * k + 1));
    return (SEED_FB+1)'(isqrt64((den << (2 * SEED_FB)) / num));
  endfunction

  logic [SEED_FB:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_seed
    assign tbl[k] = seed_at(k);
  end

  logic [9:0]  frac_top;
  logic [31:0] scaled;
  logic [AW-1:0] idx;

  // Position in [1,4) to slice number: (M-1)*DEPTH/3 on the top bits
  assign frac_top = 10'((m_fix - ONE_FX) >> (F - 8));
  assign scaled   = (32'(frac_top) * 32'(DEPTH)) / 32'd768;
  assign idx      = (scaled < 32'(DEPTH)) ? AW'(scaled) : AW'(DEPTH - 1);
  assign y0       = W'(tbl[idx]) << (F - SEED_FB);

endmodule

// File: rtl/gsqrt_fxmul.sv
module gsqrt_fxmul #(
  parameter int W = 32,
  parameter int F = 29
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] p
);
  logic signed [2*W-1:0] full;

  assign full = a * b;
  assign p    = W'(full >>> F);

endmodule

// File: rtl/gsqrt_pack.sv
module gsqrt_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GUARD = 6,
  localparam int DW   = 1 + EXP_W + MAN_W,
  localparam int F    = MAN_W + GUARD,
  localparam int W    = F + 3
) (
  input  logic signed [W-1:0] g,
  input  logic [EXP_W-1:0]    half_exp,
  output logic [DW-1:0]       word
);
  logic [MAN_W-1:0] mant;
  logic [EXP_W-1:0] e_out;

  // Bring g into [1,2), truncate, drop the hidden bit
  always_comb begin
    if (g[F+1]) begin
      mant  = MAN_W'(g >> (F + 1 - MAN_W));
      e_out = half_exp + 1'b1;
    end else if (g[F]) begin
      mant  = MAN_W'(g >> (F - MAN_W));
      e_out = half_exp;
    end else begin
      mant  = MAN_W'(g >> (F - 1 - MAN_W));
      e_out = half_exp - 1'b1;
    end
  end

  assign word = {1'b0, e_out, mant};

endmodule

// File: rtl/fp_sqrt_gs.sv
module fp_sqrt_gs #(
  parameter int EXP_W      = 8,
  parameter int MAN_W      = 23,
  parameter int ITERS      = 3,
  parameter int SEED_DEPTH = 16,
  parameter int SEED_FB    = 12,
  parameter int GUARD      = 6,
  localparam int DW        = 1 + EXP_W + MAN_W,
  localparam int F         = MAN_W + GUARD,
  localparam int W         = F + 3,
  localparam int CNT_W     = $clog2(ITERS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_invalid
);
  import gsqrt_pkg::*;

  localparam logic signed [W-1:0] ONE_FX  = {{(W-F-1){1'b0}}, 1'b1, {F{1'b0}}};
  localparam logic signed [W-1:0] HALF_FX = ONE_FX >>> 1;
  localparam logic [DW-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  gs_state_e state;

  logic                 is_special, special_flag;
  logic [DW-1:0]        special_word, packed_word;
  logic signed [W-1:0]  m_fix, y0;
  logic [EXP_W-1:0]     half_exp;

  logic signed [W-1:0]  m_q, g_q, h_q, r_q;
  logic [EXP_W-1:0]     exp_q;
  logic [CNT_W-1:0]     it_q;
  logic [DW-1:0]        res_q;
  logic                 inv_q, ov_q;

  logic signed [W-1:0]  mul_a_x, mul_a_y, prod_a, prod_b;

  gsqrt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) unpack_i (
    .op           (in_data),
    .is_special   (is_special),
    .special_word (special_word),
    .special_flag (special_flag),
    .m_fix        (m_fix),
    .half_exp     (half_exp)
  );

  gsqrt_seed_rom #(.DEPTH(SEED_DEPTH), .SEED_FB(SEED_FB), .F(F), .W(W)) seed_i (
    .m_fix (m_q),
    .y0    (y0)
  );

  // Shared multiplier A: M*y0 at seeding, g*h for the residual, g*r for the update
  always_comb begin
    case (state)
      ST_SEED: begin mul_a_x = m_q; mul_a_y = y0;  end
      ST_UPD:  begin mul_a_x = g_q; mul_a_y = r_q; end
      default: begin mul_a_x = g_q; mul_a_y = h_q; end
    endcase
  end

  gsqrt_fxmul #(.W(W), .F(F)) mul_a_i (.a(mul_a_x), .b(mul_a_y), .p(prod_a));
  // Multiplier B: h*r, used in the update phase alongside A
  gsqrt_fxmul #(.W(W), .F(F)) mul_b_i (.a(h_q), .b(r_q), .p(prod_b));

  gsqrt_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) pack_i (
    .g        (g_q),
    .half_exp (exp_q),
    .word     (packed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      m_q   <= '0;
      g_q   <= '0;
      h_q   <= '0;
      r_q   <= '0;
      exp_q <= '0;
      it_q  <= '0;
      res_q <= '0;
      inv_q <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          if (is_special) begin
            res_q <= special_word;
            inv_q <= special_flag;
            ov_q  <= 1'b1;
            state <= ST_OUT;
          end else begin
            m_q   <= m_fix;
            exp_q <= half_exp;
            state <= ST_SEED;
          end
        end
        ST_SEED: begin
          g_q   <= prod_a;
          h_q   <= y0 >>> 1;
          it_q  <= '0;
          state <= ST_RES;
        end
        ST_RES: begin
          r_q   <= HALF_FX - prod_a;
          state <= ST_UPD;
        end
        ST_UPD: begin
          g_q   <= g_q + prod_a;
          h_q   <= h_q + prod_b;
          it_q  <= it_q + 1'b1;
          state <= (it_q == CNT_W'(ITERS - 1)) ? ST_NORM : ST_RES;
        end
        ST_NORM: begin
          res_q <= packed_word;
          inv_q <= 1'b0;
          ov_q  <= 1'b1;
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          ov_q  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = ov_q;
  assign out_data    = res_q;
  assign out_invalid = inv_q;

  // R1
  accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid));

  // R2
  no_input_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5
  result_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state) == ST_NORM) || ($past(state) == ST_IDLE));

  // R5
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UPD) |-> (it_q < CNT_W'(ITERS)));

  // R3
  root_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM) |-> !g_q[W-1] && (g_q[F+1] || g_q[F] || g_q[F-1]));

  // R6
  nan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_data == QNAN_W);

  // R10
  neg_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[DW-1] |-> !out_invalid && (out_data[DW-2:0] == '0));

endmodule

// File: tb/fp_sqrt_gs_tb.sv
`timescale 1ns/1ps
module fp_sqrt_gs_tb_top;

  localparam int ITERS  = 3;
  localparam int LAT_N  = 2 * ITERS + 3;
  localparam logic [31:0] QNAN = 32'h7FC00000;
  localparam logic [31:0] PINF = 32'h7F800000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_invalid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  fp_sqrt_gs #(.EXP_W(8), .MAN_W(23), .ITERS(ITERS)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_invalid
  );

  function automatic real pow2(input int n);
    real v = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) v = v * 2.0;
    else        for (int i = 0; i < -n; i++) v = v / 2.0;
    return v;
  endfunction

  function automatic real to_real(input logic [31:0] x);
    real v;
    v = (1.0 + real'(x[22:0]) / 8388608.0) * pow2(int'(x[30:23]) - 127);
    return x[31] ? -v : v;
  endfunction

  function automatic real ulp_of(input real v);
    real p = 1.0;
    for (int i = 0; i < 300 && p * 2.0 <= v; i++) p = p * 2.0;
    for (int i = 0; i < 300 && p > v; i++) p = p / 2.0;
    return p / 8388608.0;
  endfunction

  task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input logic [31:0] op, input logic [31:0] got);
    real exact, diff;
    exact = $sqrt(to_real(op));
    diff  = to_real(got) - exact;
    if (diff < 0.0) diff = -diff;
    n_tests++;
    if (got[31] || got[30:23] == 8'hFF || diff > 2.0 * ulp_of(exact)) begin
      n_fail++;
      $display("FAIL %s sqrt(%h): actual %h (%g) expected %g", req, op, got, to_real(got), exact);
    end
  endtask

  // Single operation; lat = edge number (accepting edge is 1) at which out_valid rose
  task automatic run_op(input logic [31:0] x, output logic [31:0] y, output logic f, output int lat);
    @(negedge clk);
    in_data  = x;
    in_valid = 1'b1;
    for (int i = 0; i < 50 && !in_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    for (int i = 0; i < 100 && !out_valid; i++) begin
      @(negedge clk);
      lat++;
    end
    y = out_data;
    f = out_invalid;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk_eq("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk_eq("R1", "in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_normal_values;
    logic [31:0] ops [12] = '{32'h3F800000, 32'h40800000, 32'h41100000, 32'h40400000,
                              32'h40490FDB, 32'h3F7FFFFF, 32'h407FFFFF, 32'h60AD78EC,
                              32'h1E3CE508, 32'h7F7FFFFF, 32'h00800000, 32'h42C80000};
    logic [31:0] y; logic f; int lat;
    foreach (ops[i]) begin
      run_op(ops[i], y, f, lat);
      chk_near("R3", ops[i], y);
      chk_eq("R10", "invalid flag on positive normal", 32'(f), 32'd0);
      chk_eq("R5", "normal latency", 32'(lat), 32'(LAT_N));
    end
  endtask

  task automatic t_odd_exp;
    logic [31:0] y; logic f; int lat;
    run_op(32'h40000000, y, f, lat);
    chk_eq("R4", "exp field sqrt(2.0)", 32'(y[30:23]), 32'd127);
    chk_near("R4", 32'h40000000, y);
    run_op(32'h41000000, y, f, lat);
    chk_eq("R4", "exp field sqrt(8.0)", 32'(y[30:23]), 32'd128);
    chk_near("R4", 32'h41000000, y);
    run_op(32'h3F000000, y, f, lat);
    chk_eq("R4", "exp field sqrt(0.5)", 32'(y[30:23]), 32'd126);
    chk_near("R4", 32'h3F000000, y);
  endtask

  task automatic t_negative;
    logic [31:0] ops [3] = '{32'hC0800000, 32'hFF800000, 32'h80800000};
    logic [31:0] y; logic f; int lat;
    foreach (ops[i]) begin
      run_op(ops[i], y, f, lat);
      chk_eq("R6", "negative gives qNaN", y, QNAN);
      chk_eq("R6", "negative sets invalid", 32'(f), 32'd1);
      chk_eq("R5", "special latency", 32'(lat), 32'd1);
    end
  endtask

  task automatic t_nan;
    logic [31:0] ops [3] = '{32'h7FC00000, 32'h7F800001, 32'hFFC00000};
    logic [31:0] y; logic f; int lat;
    foreach (ops[i]) begin
      run_op(ops[i], y, f, lat);
      chk_eq("R7", "NaN gives qNaN", y, QNAN);
      chk_eq("R7", "NaN sets invalid", 32'(f), 32'd1);
    end
  endtask

  task automatic t_zero;
    logic [31:0] ops [4] = '{32'h00000000, 32'h80000000, 32'h00400000, 32'h80000001};
    logic [31:0] y; logic f; int lat;
    foreach (ops[i]) begin
      run_op(ops[i], y, f, lat);
      chk_eq("R8", "signed zero result", y, {ops[i][31], 31'd0});
      chk_eq("R8", "zero keeps invalid low", 32'(f), 32'd0);
      chk_eq("R5", "zero latency", 32'(lat), 32'd1);
    end
  endtask

  task automatic t_inf;
    logic [31:0] y; logic f; int lat;
    run_op(PINF, y, f, lat);
    chk_eq("R9", "+inf result", y, PINF);
    chk_eq("R9", "+inf invalid low", 32'(f), 32'd0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held; logic [31:0] y; int lat;
    @(negedge clk);
    in_data = 32'h41100000;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_data = 32'h41800000;              // next operand offered while busy
    for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
    held = out_data;
    chk_near("R2", 32'h41100000, held);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_eq("R2", "out_valid held", 32'(out_valid), 32'd1);
      chk_eq("R2", "out_data held", out_data, held);
      chk_eq("R1", "in_ready low while result held", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);                      // handshake edge passed; unit idle
    out_ready = 1'b0;
    chk_eq("R2", "out_valid cleared by handshake", 32'(out_valid), 32'd0);
    chk_eq("R2", "in_ready back after handshake", 32'(in_ready), 32'd1);
    @(posedge clk);                      // pending operand accepted here
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    for (int i = 0; i < 100 && !out_valid; i++) begin
      @(negedge clk);
      lat++;
    end
    y = out_data;
    chk_near("R1", 32'h41800000, y);
    chk_eq("R5", "latency after stall", 32'(lat), 32'(LAT_N));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_values();
    t_odd_exp();
    t_negative();
    t_nan();
    t_zero();
    t_inf();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule